// File: doc/BRIEF.md
# Frame-End Interrupt Status Aggregator

This block sits between the transfer-descriptor updater of a USB host controller and the controller's status register. During a frame, the updater reports three kinds of descriptor event as one-cycle pulses. The first is a completion, meaning a descriptor with its interrupt-on-complete flag set was found inactive. The second is an error retirement, meaning the error countdown reached zero. The third is a short packet. The block gathers these pulses in a private shadow register. Nothing becomes visible to software until the updater signals that the last status writeback of the frame has reached memory.

On that frame-end pulse, the shadow is moved into two sticky status bits and then emptied. The two bits are a general USB interrupt bit and a USB error bit. Software clears a status bit by writing a one to it. An interrupt-enable register has one enable per event kind. The single level interrupt output is high while any posted event has its matching enable set.

Top module: `fei_top`

## Requirements
- R1: A status bit never goes from 0 to 1 except in the cycle right after a `frame_end` pulse. Events that arrive before that pulse stay invisible on `reg_rdata`.
- R2: A completion event (`ev_ioc`) in a frame sets status bit 0 (USB interrupt) at frame end.
- R3: An error retirement (`ev_err`) in a frame sets both status bit 0 and status bit 1 (USB error) at frame end.
- R4: A short-packet event (`ev_spd`) in a frame sets status bit 0 at frame end.
- R5: The enable register (`reg_sel`=1) holds the error/time-out enable at bit 0, the completion enable at bit 2 and the short-packet enable at bit 3. Bit 1 reads 0, and the register reads back what was written.
- R6: `irq` is high while a posted cause has its enable set: error with bit 0, completion with bit 2, short packet with bit 3. Clearing status bit 0 withdraws the completion and short-packet causes. Clearing status bit 1 withdraws the error cause.
- R7: An event that arrives in the same cycle as `frame_end` is not posted by that pulse. It is posted by the next one.
- R8: Writing 1 to a status bit (`reg_sel`=0) clears it. Writing 0 leaves it unchanged.
- R9: If a clear and a frame-end post hit the same status bit in the same cycle, the bit ends up set.
- R10: After reset, the status bits, the enables and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ioc | input | 1 | Completion event pulse |
| ev_err | input | 1 | Error-retirement event pulse |
| ev_spd | input | 1 | Short-packet event pulse |
| frame_end | input | 1 | Last status writeback of the frame has finished |
| reg_sel | input | 1 | 0 selects status, 1 selects enables |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach from the ports are the two same-cycle collisions. In one, an event pulse lands on the `frame_end` cycle. In the other, a software clear lands on the cycle that posts the same bit. The bench builds each one on purpose. For the first, it fires an event together with `frame_end` while the shadow is empty, checks that the status stays 0, and then ends a second frame to see the deferred post. For the second, it leaves a completion pending, clears status, and then issues a write-one clear in the same cycle as `frame_end`.

// File: rtl/fei_pkg.sv
package fei_pkg;
    localparam int REG_W  = 4;
    localparam int ST_W   = 2;
    localparam int ST_INT = 0;
    localparam int ST_ERR = 1;
    localparam int EN_CRC = 0;
    localparam int EN_IOC = 2;
    localparam int EN_SPD = 3;

    typedef struct packed {
        logic ioc;
        logic err;
        logic spd;
    } fei_ev_t;
endpackage

// File: rtl/fei_pending.sv
module fei_pending
    import fei_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fei_ev_t ev_in,
    input  logic    frame_end,
    output fei_ev_t pend
);
    typedef struct packed {
        fei_ev_t pend;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_end) begin
            // shadow is handed over; same-cycle events start the next frame
            s_d.pend = ev_in;
        end else begin
            s_d.pend = s_q.pend | ev_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;

    // R7: after a frame end the shadow holds only the events of that cycle
    assert_defer_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pend == $past(ev_in)));
endmodule

// File: rtl/fei_status.sv
module fei_status
    import fei_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fei_ev_t          post,
    input  logic             post_vld,
    input  logic             clr_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [ST_W-1:0]  status,
    output logic [REG_W-1:0] enables,
    output logic             irq
);
    typedef struct packed {
        logic [ST_W-1:0] st;
        fei_ev_t         cause;
        logic            crc_en;
        logic            ioc_en;
        logic            spd_en;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_wr) begin
            s_d.crc_en = wdata[EN_CRC];
            s_d.ioc_en = wdata[EN_IOC];
            s_d.spd_en = wdata[EN_SPD];
        end
        if (clr_wr) begin
            if (wdata[ST_INT]) begin
                s_d.st[ST_INT]  = 1'b0;
                s_d.cause.ioc   = 1'b0;
                s_d.cause.spd   = 1'b0;
            end
            if (wdata[ST_ERR]) begin
                s_d.st[ST_ERR]  = 1'b0;
                s_d.cause.err   = 1'b0;
            end
        end
        // a post applied after the clear so it wins on collision
        if (post_vld) begin
            if (post.ioc || post.err || post.spd) s_d.st[ST_INT] = 1'b1;
            if (post.err)                         s_d.st[ST_ERR] = 1'b1;
            s_d.cause = s_d.cause | post;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status  = s_q.st;
    assign enables = {s_q.spd_en, s_q.ioc_en, 1'b0, s_q.crc_en};
    assign irq     = (s_q.cause.err & s_q.crc_en) |
                     (s_q.cause.ioc & s_q.ioc_en) |
                     (s_q.cause.spd & s_q.spd_en);

    assert_no_early_post_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !post_vld |=> ((status & ~$past(status)) == '0));

    assert_err_sets_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && post.err) |=> (status == 2'b11));

    assert_post_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && (post.ioc || post.spd)) |=> status[ST_INT]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_INT] && !clr_wr) |=> status[ST_INT]);

    assert_irq_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: rtl/fei_top.sv
module fei_top
    import fei_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_ioc,
    input  logic             ev_err,
    input  logic             ev_spd,
    input  logic             frame_end,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    fei_ev_t          ev_in;
    fei_ev_t          pend;
    logic [ST_W-1:0]  status;
    logic [REG_W-1:0] enables;

    assign ev_in = '{ioc: ev_ioc, err: ev_err, spd: ev_spd};

    fei_pending i_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_in     (ev_in),
        .frame_end (frame_end),
        .pend      (pend)
    );

    fei_status i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (pend),
        .post_vld (frame_end),
        .clr_wr   (reg_wr && !reg_sel),
        .en_wr    (reg_wr && reg_sel),
        .wdata    (reg_wdata),
        .status   (status),
        .enables  (enables),
        .irq      (irq)
    );

    always_comb begin
        if (reg_sel) reg_rdata = enables;
        else         reg_rdata = {{(REG_W-ST_W){1'b0}}, status};
    end

    // R5: enable bit 1 never reads back as set
    assert_en_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> !reg_rdata[1]);
endmodule

// File: tb/test_fei_top.sv
module test_fei_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_ioc = 1'b0, ev_err = 1'b0, ev_spd = 1'b0, frame_end = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       irq;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fei_top i_fei_top (.*);

    // {ioc, err, spd, en[3:0], status[1:0], irq}
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        {3'b100, 4'b0100, 2'b01, 1'b1},
        {3'b100, 4'b0000, 2'b01, 1'b0},
        {3'b010, 4'b0001, 2'b11, 1'b1},
        {3'b010, 4'b0100, 2'b11, 1'b0},
        {3'b001, 4'b1000, 2'b01, 1'b1},
        {3'b001, 4'b0100, 2'b01, 1'b0},
        {3'b000, 4'b1101, 2'b00, 1'b0},
        {3'b101, 4'b1000, 2'b01, 1'b1},
        {3'b110, 4'b0001, 2'b11, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [3:0] d);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
    endtask

    task automatic rd_status(output int v);
        reg_sel = 1'b0; #1 v = int'(reg_rdata);
    endtask

    task automatic end_frame();
        frame_end = 1'b1; tick(); frame_end = 1'b0;
    endtask

    task automatic pulse(logic i, logic e, logic s);
        ev_ioc = i; ev_err = e; ev_spd = s;
        tick();
        ev_ioc = 1'b0; ev_err = 1'b0; ev_spd = 1'b0;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rd_status(v); chk("R10 status", v, 0);
        reg_sel = 1'b1; #1 chk("R10 enables", int'(reg_rdata), 0);
        chk("R10 irq", int'(irq), 0);
        rst_n = 1'b1;
        tick();

        for (int k = 0; k < NV; k++) begin
            wr(1'b0, 4'b0011);
            end_frame();
            wr(1'b0, 4'b0011);
            wr(1'b1, VEC[k][6:3]);
            pulse(VEC[k][9], VEC[k][8], VEC[k][7]);
            tick();
            rd_status(v); chk("R1 hidden before frame end", v, 0);
            chk("R1 irq before frame end", int'(irq), 0);
            end_frame();
            rd_status(v);
            chk($sformatf("R2/R3/R4 status vec %0d", k), v, int'(VEC[k][2:1]));
            chk($sformatf("R6 irq vec %0d", k), int'(irq), int'(VEC[k][0]));
        end

        // R5: enable layout readback
        wr(1'b1, 4'b1111);
        reg_sel = 1'b1; #1 chk("R5 readback", int'(reg_rdata), 4'b1101);
        reg_sel = 1'b0;

        // R8: write 0 keeps status, write 1 clears; R6 clearing drops irq
        wr(1'b0, 4'b0011); end_frame(); wr(1'b0, 4'b0011);
        pulse(1'b1, 1'b0, 1'b0); end_frame();
        wr(1'b0, 4'b0000);
        rd_status(v); chk("R8 write 0 no effect", v, 1);
        chk("R6 irq set", int'(irq), 1);
        wr(1'b0, 4'b0001);
        rd_status(v); chk("R8 write 1 clears", v, 0);
        chk("R6 irq withdrawn", int'(irq), 0);

        // R7: event on the frame_end cycle is deferred
        end_frame();
        ev_spd = 1'b1; frame_end = 1'b1; tick();
        ev_spd = 1'b0; frame_end = 1'b0;
        rd_status(v); chk("R7 same-cycle not posted", v, 0);
        end_frame();
        rd_status(v); chk("R7 posted next frame", v, 1);

        // R9: clear and post collide
        wr(1'b0, 4'b0011);
        pulse(1'b1, 1'b0, 1'b0);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 4'b0001; frame_end = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; frame_end = 1'b0;
        rd_status(v); chk("R9 post wins", v, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule